// File: doc/BRIEF.md
# Memory-Mapped 8-Bit GPIO Port

This block is an eight-pin general-purpose I/O port on a simple synchronous register bus. The bus has a 16-bit address, single-cycle write and read strobes, and 8-bit data. Software sets a per-pin direction and an output value. The port drives an output enable and an output level for each pin toward the pad logic. The live pin levels come back through a synchronizer and can be read as a separate read-only register.

The port has two reset inputs and two standby indications, and each acts on a different part of the state:

- **Power-on reset** clears everything.
- **Hardware standby** clears the direction and output registers and blocks writes while it is high.
- **Manual reset** leaves the direction and output registers untouched. It clears only the bus read path and the synchronizer, and it blocks writes while it is low.
- **Software standby** freezes the registers by blocking writes.

The direction register is write-only. A read of its address returns a fixed pattern that does not reveal what was written.

Top module: `gpio8_port`

## Requirements
- R1: Bit n of `pin_oe` equals bit n of the direction register; a 1 makes pin n an output, a 0 makes it an input.
- R2: Bit n of `pin_out` equals bit n of the output register.
- R3: A write is captured on the rising edge where `bus_wr` is sampled high, and the pin outputs show the new value in the cycle after that edge, not before.
- R4: The direction register is write-only: a read at its address returns a value that does not depend on the stored direction bits.
- R5: The output register reads back the last value written to it.
- R6: The pin-state register returns `pin_in` after a two-flop synchronizer. A level held on `pin_in` across edges k and k+1 is returned by a read strobed at edge k+2.
- R7: While `por_n` is low at a rising edge, the direction register, the output register, the synchronizer and `bus_rdata` all clear to 0x00.
- R8: While `hw_stby` is high at a rising edge, the direction and output registers clear to 0x00 and ignore writes.
- R9: While `mrst_n` is low, the direction and output registers keep their contents, writes are ignored, and `bus_rdata` and the synchronizer clear to 0x00.
- R10: While `sw_stby` is high, the direction and output registers keep their contents and ignore writes.
- R11: A write to the pin-state address or to any unmapped address changes no register, and a read of an unmapped address returns 0x00.
- R12: Read data is registered. `bus_rdata` takes the selected value on the edge where `bus_rd` is sampled high and holds otherwise.
- R13: The decode uses all 16 address bits: 0xFE36 selects direction, 0xFF06 selects output data, and 0xFFB6 selects pin state.
- R14: When `bus_rd` and `bus_wr` are both high for the output register in one cycle, the read returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| hw_stby | input | 1 | Hardware standby indication, active high |
| sw_stby | input | 1 | Software standby indication, active high |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from pad logic |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output level |

## Verification
Two things can land in the same clock edge:

- A register write together with a read of that same register.
- A write together with a reset or standby condition that has to win over it.

The bench forces both cases directly. It strobes a read and a write to the output register together, and it issues writes while manual reset, hardware standby or software standby is active. Random mixes with standby and manual reset toggled at random rates then repeat these collisions. A cycle-level reference model in the bench judges each outcome from the requirement rules: the read returns the old value, and the reset or standby rule wins over the write.

// File: rtl/gpio8_pkg.sv
// Shared types for the GPIO port: register select produced by the decoder.
package gpio8_pkg;

    // Which register a bus access targets.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_OUT  = 2'd2,
        SEL_PIN  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio8_addr_decode.sv
// Address decoder: compares the full bus address against the three register
// addresses and names the selected register. Assumes the addresses differ.
module gpio8_addr_decode
    import gpio8_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFE36,
    parameter logic [ADDR_W-1:0] OUT_ADDR = 16'hFF06,
    parameter logic [ADDR_W-1:0] PIN_ADDR = 16'hFFB6
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Full-width compare; anything else is unmapped.
    always_comb begin
        if (addr == DIR_ADDR)      sel = SEL_DIR;
        else if (addr == OUT_ADDR) sel = SEL_OUT;
        else if (addr == PIN_ADDR) sel = SEL_PIN;
        else                       sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio8_ctrl_regs.sv
// Direction and output registers. Both clear on power-on reset or hardware
// standby and keep their contents through manual reset and software standby.
// Writes are accepted only when no reset or standby condition is active.
module gpio8_ctrl_regs
    import gpio8_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] out_q
);

    logic wr_ok;

    // Gate writes off during manual reset and either standby.
    always_comb wr_ok = wr && mrst_n && !hw_stby && !sw_stby;

    // Direction register: cleared by power-on reset or hardware standby.
    always_ff @(posedge clk) begin
        if (!por_n || hw_stby)            dir_q <= '0;
        else if (wr_ok && sel == SEL_DIR) dir_q <= wdata;
    end

    // Output register: same reset rule as direction.
    always_ff @(posedge clk) begin
        if (!por_n || hw_stby)            out_q <= '0;
        else if (wr_ok && sel == SEL_OUT) out_q <= wdata;
    end

endmodule

// File: rtl/gpio8_pin_sync.sv
// Multi-stage synchronizer for the pin inputs. Cleared by power-on or manual
// reset. Assumes STAGES >= 1; the last stage feeds the pin-state register.
module gpio8_pin_sync #(
    parameter int PORT_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_q
);

    logic [PORT_W-1:0] stg [STAGES];

    // Shift the pin levels through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= pin_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign pin_q = stg[STAGES-1];

endmodule

// File: rtl/gpio8_read_mux.sv
// Registered read path. Captures the selected register on a read strobe and
// holds otherwise. The direction address returns a fixed pattern so stored
// direction bits never leave the block.
module gpio8_read_mux
    import gpio8_pkg::*;
#(
    parameter int                PORT_W       = 8,
    parameter logic [PORT_W-1:0] DIR_RD_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [PORT_W-1:0] out_q,
    input  logic [PORT_W-1:0] pin_q,
    output logic [PORT_W-1:0] rdata
);

    logic [PORT_W-1:0] rd_next;

    // Pick the read value for the addressed register.
    always_comb begin
        case (sel)
            SEL_DIR: rd_next = DIR_RD_VALUE;
            SEL_OUT: rd_next = out_q;
            SEL_PIN: rd_next = pin_q;
            default: rd_next = '0;
        endcase
    end

    // Register the read data on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_next;
    end

endmodule

// File: rtl/gpio8_port.sv
// Top of the GPIO port: decode, control registers, pin synchronizer and read
// path. Pad outputs come straight from the control registers, so a write is
// visible on the pins in the cycle after the write edge. Resets are
// synchronous and active low.
module gpio8_port
    import gpio8_pkg::*;
#(
    parameter int                PORT_W      = 8,
    parameter int                ADDR_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFE36,
    parameter logic [ADDR_W-1:0] OUT_ADDR    = 16'hFF06,
    parameter logic [ADDR_W-1:0] PIN_ADDR    = 16'hFFB6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out
);

    localparam logic [PORT_W-1:0] DIR_RD_VALUE = '0;

    reg_sel_e          sel;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] out_q;
    logic [PORT_W-1:0] pin_q;
    logic              path_rst_n;

    // Read path and synchronizer answer to both resets.
    always_comb path_rst_n = por_n && mrst_n;

    gpio8_addr_decode #(
        .ADDR_W   (ADDR_W),
        .DIR_ADDR (DIR_ADDR),
        .OUT_ADDR (OUT_ADDR),
        .PIN_ADDR (PIN_ADDR)
    ) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio8_ctrl_regs #(
        .PORT_W (PORT_W)
    ) regs_i (
        .clk     (clk),
        .por_n   (por_n),
        .mrst_n  (mrst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .out_q   (out_q)
    );

    gpio8_pin_sync #(
        .PORT_W (PORT_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (path_rst_n),
        .pin_in (pin_in),
        .pin_q  (pin_q)
    );

    gpio8_read_mux #(
        .PORT_W       (PORT_W),
        .DIR_RD_VALUE (DIR_RD_VALUE)
    ) rmux_i (
        .clk   (clk),
        .rst_n (path_rst_n),
        .rd    (bus_rd),
        .sel   (sel),
        .out_q (out_q),
        .pin_q (pin_q),
        .rdata (bus_rdata)
    );

    // Pad drive follows the control registers.
    assign pin_oe  = dir_q;
    assign pin_out = out_q;

endmodule

// File: rtl/gpio8_port_chk.sv
// Checker for gpio8_port, bound to every instance. Observes ports only.
module gpio8_port_chk #(
    parameter int                PORT_W   = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFE36,
    parameter logic [ADDR_W-1:0] OUT_ADDR = 16'hFF06,
    parameter logic [ADDR_W-1:0] PIN_ADDR = 16'hFFB6
) (
    input logic              clk,
    input logic              por_n,
    input logic              mrst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] pin_out
);

    logic wr_allowed;
    logic unmapped;

    always_comb wr_allowed = bus_wr && mrst_n && !hw_stby && !sw_stby;
    always_comb unmapped = (bus_addr != DIR_ADDR) && (bus_addr != OUT_ADDR)
                        && (bus_addr != PIN_ADDR);

    // R1 R3: accepted direction write shows on pin_oe next cycle.
    p_dir_write_r1: assert property (@(posedge clk) disable iff (!por_n)
        (wr_allowed && bus_addr == DIR_ADDR) |=> (pin_oe == $past(bus_wdata)));

    // R2 R3: accepted output write shows on pin_out next cycle.
    p_out_write_r2: assert property (@(posedge clk) disable iff (!por_n)
        (wr_allowed && bus_addr == OUT_ADDR) |=> (pin_out == $past(bus_wdata)));

    // R7: power-on reset clears the pad drive.
    p_por_clear_r7: assert property (@(posedge clk)
        !por_n |=> (pin_oe == '0 && pin_out == '0));

    // R8: hardware standby clears the pad drive.
    p_hw_stby_clear_r8: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (pin_oe == '0 && pin_out == '0));

    // R9: manual reset keeps the pad drive.
    p_mrst_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && !hw_stby) |=> ($stable(pin_oe) && $stable(pin_out)));

    // R10: software standby keeps the pad drive.
    p_sw_stby_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
        (sw_stby && !hw_stby) |=> ($stable(pin_oe) && $stable(pin_out)));

    // R11: unmapped reads return zero.
    p_unmapped_rd_r11: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && mrst_n && unmapped) |=> (bus_rdata == '0));

    // R12: read data holds without a strobe.
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
        (!bus_rd && mrst_n) |=> $stable(bus_rdata));

endmodule

bind gpio8_port gpio8_port_chk #(
    .PORT_W   (PORT_W),
    .ADDR_W   (ADDR_W),
    .DIR_ADDR (DIR_ADDR),
    .OUT_ADDR (OUT_ADDR),
    .PIN_ADDR (PIN_ADDR)
) chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .mrst_n    (mrst_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/gpio8_port_tb_top.sv
// Self-checking bench for gpio8_port: directed corner cases plus seeded random
// traffic, judged against a cycle-level reference model kept in the bench.
module gpio8_port_tb_top;

    localparam logic [15:0] A_DIR = 16'hFE36;
    localparam logic [15:0] A_OUT = 16'hFF06;
    localparam logic [15:0] A_PIN = 16'hFFB6;

    logic        clk = 1'b0;
    logic        por_n, mrst_n, hw_stby, sw_stby;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata, pin_in, pin_oe, pin_out;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state.
    logic [7:0] m_dir, m_out, m_s1, m_s2, m_rd;
    bit         m_rd_dc;

    always #4 clk = ~clk;

    gpio8_port dut_i (
        .clk (clk), .por_n (por_n), .mrst_n (mrst_n), .hw_stby (hw_stby),
        .sw_stby (sw_stby), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_oe (pin_oe), .pin_out (pin_out)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Model update for one rising edge, from the inputs being driven.
    function automatic void model_edge();
        logic [7:0] nxt_rd;
        if (!por_n) begin
            m_dir = '0; m_out = '0; m_s1 = '0; m_s2 = '0; m_rd = '0; m_rd_dc = 0;
            return;
        end
        nxt_rd = m_rd;
        if (!mrst_n) begin
            nxt_rd = '0; m_rd_dc = 0;
        end else if (bus_rd) begin
            m_rd_dc = (bus_addr == A_DIR);
            nxt_rd  = (bus_addr == A_OUT) ? m_out :
                      (bus_addr == A_PIN) ? m_s2 : 8'h00;
        end
        if (!mrst_n) begin
            m_s2 = '0; m_s1 = '0;
        end else begin
            m_s2 = m_s1; m_s1 = pin_in;
        end
        if (hw_stby) begin
            m_dir = '0; m_out = '0;
        end else if (bus_wr && mrst_n && !sw_stby) begin
            if (bus_addr == A_DIR) m_dir = bus_wdata;
            if (bus_addr == A_OUT) m_out = bus_wdata;
        end
        m_rd = nxt_rd;
    endfunction

    // One cycle: inputs already set at a falling edge; compare at next one.
    task automatic step(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(pin_oe == m_dir, {req, " R1"}, pin_oe, m_dir);
        check(pin_out == m_out, {req, " R2"}, pin_out, m_out);
        if (!m_rd_dc) check(bus_rdata == m_rd, {req, " R12"}, bus_rdata, m_rd);
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        step(req);
        idle();
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        bus_addr = a; bus_rd = 1; bus_wr = 0;
        step(req);
        idle();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=00 expected=01");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v1, v2;
        void'($urandom(32'd20240611));
        por_n = 0; mrst_n = 1; hw_stby = 0; sw_stby = 0;
        bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; pin_in = 8'h00;
        m_dir = 'x; m_out = 'x; m_s1 = 'x; m_s2 = 'x; m_rd = 'x; m_rd_dc = 0;
        @(negedge clk);
        step("R7 reset");
        step("R7 reset");
        check(bus_rdata == 8'h00, "R7 rdata", bus_rdata, 8'h00);
        por_n = 1;
        step("R7 idle");

        // R3: value must not be visible before the write edge.
        bus_addr = A_DIR; bus_wdata = 8'hC3; bus_wr = 1;
        #1 check(pin_oe == 8'h00, "R3 before edge", pin_oe, 8'h00);
        step("R3 dir write");
        idle();
        check(pin_oe == 8'hC3, "R3 after edge", pin_oe, 8'hC3);
        wr(A_OUT, 8'h5A, "R5");
        rd(A_OUT, "R5");
        check(bus_rdata == 8'h5A, "R5 readback", bus_rdata, 8'h5A);

        // R4: direction read is independent of stored bits.
        rd(A_DIR, "R4"); v1 = bus_rdata;
        wr(A_DIR, 8'h3C, "R4");
        rd(A_DIR, "R4"); v2 = bus_rdata;
        check(v1 == v2, "R4 write-only", v2, v1);

        // R13: near-miss addresses do not decode.
        wr(16'h0E36, 8'hFF, "R13");
        wr(16'hFE37, 8'hFF, "R13");
        check(pin_oe == 8'h3C, "R13 decode", pin_oe, 8'h3C);
        // R11: pin-state and unmapped writes ignored, unmapped read zero.
        wr(A_PIN, 8'hFF, "R11");
        wr(16'h1234, 8'hFF, "R11");
        check(pin_out == 8'h5A, "R11 ignored", pin_out, 8'h5A);
        rd(16'h1234, "R11");
        check(bus_rdata == 8'h00, "R11 unmapped", bus_rdata, 8'h00);

        // R6: two-stage latency of pin levels.
        pin_in = 8'hA7;
        rd(A_PIN, "R6");
        check(bus_rdata == 8'h00, "R6 first", bus_rdata, 8'h00);
        rd(A_PIN, "R6");
        check(bus_rdata == 8'h00, "R6 second", bus_rdata, 8'h00);
        rd(A_PIN, "R6");
        check(bus_rdata == 8'hA7, "R6 third", bus_rdata, 8'hA7);

        // R14: read and write of output register in one cycle.
        bus_addr = A_OUT; bus_wdata = 8'h99; bus_wr = 1; bus_rd = 1;
        step("R14"); idle();
        check(bus_rdata == 8'h5A, "R14 old value", bus_rdata, 8'h5A);
        check(pin_out == 8'h99, "R14 new value", pin_out, 8'h99);

        // R10: software standby blocks writes and holds.
        sw_stby = 1;
        wr(A_DIR, 8'h00, "R10"); wr(A_OUT, 8'h00, "R10");
        check(pin_oe == 8'h3C && pin_out == 8'h99, "R10 hold", pin_out, 8'h99);
        sw_stby = 0;

        // R9: manual reset keeps registers, clears read path.
        mrst_n = 0;
        wr(A_OUT, 8'h11, "R9");
        check(pin_out == 8'h99, "R9 hold", pin_out, 8'h99);
        check(bus_rdata == 8'h00, "R9 rdata", bus_rdata, 8'h00);
        mrst_n = 1;
        step("R9 release");
        check(pin_oe == 8'h3C, "R9 dir kept", pin_oe, 8'h3C);

        // R8: hardware standby clears and blocks writes.
        hw_stby = 1;
        wr(A_DIR, 8'hFF, "R8");
        check(pin_oe == 8'h00 && pin_out == 8'h00, "R8 clear", pin_oe, 8'h00);
        hw_stby = 0;
        step("R8 release");

        // R7: power-on reset mid-run.
        wr(A_DIR, 8'hF0, "R7");
        por_n = 0; step("R7 por"); por_n = 1;
        check(pin_oe == 8'h00, "R7 por clear", pin_oe, 8'h00);

        // Random traffic with collisions against reset and standby.
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 5);
            bus_addr  = (sel == 0) ? A_DIR : (sel <= 2) ? A_OUT :
                        (sel == 3) ? A_PIN : 16'($urandom);
            bus_wdata = 8'($urandom);
            bus_wr    = ($urandom_range(0, 1) == 1);
            bus_rd    = ($urandom_range(0, 1) == 1);
            pin_in    = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pin_in;
            hw_stby   = ($urandom_range(0, 30) == 0);
            sw_stby   = ($urandom_range(0, 10) == 0);
            mrst_n    = ($urandom_range(0, 20) != 0);
            por_n     = ($urandom_range(0, 200) != 0);
            step("random");
        end
        idle(); hw_stby = 0; sw_stby = 0; mrst_n = 1; por_n = 1;
        step("final");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule